// File: doc/BRIEF.md
# USB Memory and Register Access Gate

This block sits between a 32-bit system bus slave port and the USB buffer SRAM and control-register space. Every bus access is decoded into one of three windows: the SRAM window at the bottom of the block's address space, a register window of 256 bytes, and one gate control word. SRAM and register accesses go downstream only while a single access-enable bit is set. The control word holds that bit. Software can set it only while the processor's secure-mode input is high, and can clear it at any time.

Once set, the enable bit keeps granting access after the processor leaves secure mode, until software writes it back to zero. An access that is refused completes at once with an error flag and zero read data, and no downstream request is made. Refused means one of: blocked because the bit is clear, not 4-byte aligned, or outside every window. Granted accesses are handed to simple request/ready ports on the SRAM and register side. The register side carries only the low 8 data bits.

Top module: `usbSecGate`

## Requirements
- R1: After reset the enable bit is 0, `busReady`, `sramReq` and `regReq` are low, and a read of the control word returns 0.
- R2: While the enable bit is 0, an aligned SRAM or register access completes with `busErr`=1 and `busRdata`=0, and neither `sramReq` nor `regReq` is asserted.
- R3: Writing 1 to bit 0 of the control word while `cpuSecure` is 0 leaves the enable bit at 0. Such a write completes without error, and SRAM and register accesses stay refused.
- R4: Writing 1 to bit 0 of the control word while `cpuSecure` is 1 sets the enable bit. SRAM and register reads and writes are then forwarded and complete with `busErr`=0.
- R5: With the enable bit set and `cpuSecure` at 0, SRAM and register accesses are still forwarded without error.
- R6: Writing 0 to bit 0 of the control word clears the enable bit whatever the level of `cpuSecure`. Later SRAM and register accesses are refused.
- R7: Any access whose address bits [1:0] are not 00 is refused with `busErr`=1 and zero read data, even while enabled, and this includes the control word.
- R8: Register accesses drive `regWdata` with bus write data bits [7:0]. A register read returns `regRdata` in bits [7:0] with bits [31:8] at zero.
- R9: The SRAM window is bus addresses 0 to SRAM_BYTES-1, the register window is the 256 bytes at REG_BASE, and the control word is at CTRL_ADDR. Every other address is refused with `busErr`=1.
- R10: Timing is counted from the clock edge that samples `busReq`. A refused access or a control-word access raises `busReady` for one cycle after that edge. A forwarded access raises the downstream request after that edge and holds it, with a stable address, until the downstream ready is sampled. `busReady` follows one cycle later.
- R11: A control-word read returns the enable bit in bit 0 and zeros in bits [31:1].

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSecure | input | 1 | Processor secure-mode level |
| busReq | input | 1 | Access request, held until `busReady` |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Byte address |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | One-cycle completion pulse |
| busErr | output | 1 | Refused access, valid with `busReady` |
| busRdata | output | 32 | Read data, valid with `busReady` |
| sramReq | output | 1 | SRAM request, held until `sramReady` |
| sramWe | output | 1 | SRAM write strobe qualifier |
| sramAddr | output | $clog2(SRAM_BYTES) | SRAM byte address |
| sramWdata | output | 32 | SRAM write data |
| sramRdata | input | 32 | SRAM read data, valid with `sramReady` |
| sramReady | input | 1 | SRAM completion |
| regReq | output | 1 | Register request, held until `regReady` |
| regWe | output | 1 | Register write qualifier |
| regAddr | output | 8 | Register byte offset |
| regWdata | output | 8 | Register write data |
| regRdata | input | 8 | Register read data, valid with `regReady` |
| regReady | input | 1 | Register completion |

## Verification
The enable bit is the only long-lived state. A wrong value of it shows at the ports on the very next SRAM or register access, either as an error where a forward was due or as a downstream request where an error was due. It also shows on any control-word read. A sequencing fault shows within one or two cycles of the access, as a `busReady` pulse in the wrong cycle, a dropped downstream request, or nonzero read data beside an error. The stimulus therefore moves the enable bit through every transition, with `cpuSecure` at both levels, and probes it after each one with both kinds of access.

// File: rtl/usbSecGatePkg.sv
package usbSecGatePkg;
  localparam int BUS_W = 32;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {TGT_NONE, TGT_SRAM, TGT_REG, TGT_CTRL} tgt_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FWD, ST_RESP} st_e;
  typedef enum logic [1:0] {RSP_ZERO, RSP_SRAM, RSP_REG, RSP_CTRL} rsp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch address and write data of an accepted access
    logic loadResp;  // latch response data
    rsp_e respSel;   // response data source
  } strobe_t;
endpackage

// File: rtl/gateDecode.sv
module gateDecode
  import usbSecGatePkg::*;
#(
  parameter int          SRAM_AW   = 12,
  parameter logic [31:0] REG_BASE  = 32'h0001_0000,
  parameter logic [31:0] CTRL_ADDR = 32'h0002_0000
) (
  input  logic [BUS_W-1:0] addr,
  output tgt_e             hit,
  output logic             aligned
);
  logic sramHit, regHit, ctrlHit;

  assign aligned = (addr[1:0] == 2'b00);
  assign sramHit = (addr[BUS_W-1:SRAM_AW] == '0);
  assign regHit  = (addr[BUS_W-1:8] == REG_BASE[BUS_W-1:8]);
  assign ctrlHit = (addr[BUS_W-1:2] == CTRL_ADDR[BUS_W-1:2]);

  always_comb begin
    if (sramHit)      hit = TGT_SRAM;
    else if (regHit)  hit = TGT_REG;
    else if (ctrlHit) hit = TGT_CTRL;
    else              hit = TGT_NONE;
  end
endmodule

// File: rtl/gateCtrl.sv
module gateCtrl
  import usbSecGatePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuSecure,
  input  logic    busReq,
  input  logic    busWe,
  input  logic    setBit,
  input  tgt_e    hit,
  input  logic    aligned,
  input  logic    sramReady,
  input  logic    regReady,
  output logic    busReady,
  output logic    busErr,
  output logic    sramReq,
  output logic    sramWe,
  output logic    regReq,
  output logic    regWe,
  output logic    secEn,
  output strobe_t strb
);
  st_e  state, stateNx;
  tgt_e tgtQ, tgtNx;
  logic weQ, weNx, errQ, errNx, enNx;
  logic downReady;

  assign downReady = (tgtQ == TGT_SRAM) ? sramReady : regReady;

  always_comb begin
    stateNx      = state;
    tgtNx        = tgtQ;
    weNx         = weQ;
    errNx        = errQ;
    enNx         = secEn;
    strb.capture = 1'b0;
    strb.loadResp = 1'b0;
    strb.respSel = RSP_ZERO;
    unique case (state)
      ST_IDLE: if (busReq) begin
        weNx  = busWe;
        tgtNx = hit;
        strb.loadResp = 1'b1;
        if (!aligned || hit == TGT_NONE) begin
          errNx   = 1'b1;
          stateNx = ST_RESP;
        end else if (hit == TGT_CTRL) begin
          errNx   = 1'b0;
          stateNx = ST_RESP;
          strb.respSel = busWe ? RSP_ZERO : RSP_CTRL;
          if (busWe) enNx = setBit ? (secEn | cpuSecure) : 1'b0;
        end else if (!secEn) begin
          errNx   = 1'b1;
          stateNx = ST_RESP;
        end else begin
          errNx        = 1'b0;
          stateNx      = ST_FWD;
          strb.loadResp = 1'b0;
          strb.capture = 1'b1;
        end
      end
      ST_FWD: if (downReady) begin
        stateNx = ST_RESP;
        strb.loadResp = 1'b1;
        if (!weQ) strb.respSel = (tgtQ == TGT_SRAM) ? RSP_SRAM : RSP_REG;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tgtQ  <= TGT_NONE;
      weQ   <= 1'b0;
      errQ  <= 1'b0;
      secEn <= 1'b0;
    end else begin
      state <= stateNx;
      tgtQ  <= tgtNx;
      weQ   <= weNx;
      errQ  <= errNx;
      secEn <= enNx;
    end
  end

  assign busReady = (state == ST_RESP);
  assign busErr   = busReady && errQ;
  assign sramReq  = (state == ST_FWD) && (tgtQ == TGT_SRAM);
  assign regReq   = (state == ST_FWD) && (tgtQ == TGT_REG);
  assign sramWe   = sramReq && weQ;
  assign regWe    = regReq && weQ;
endmodule

// File: rtl/gateDatapath.sv
module gateDatapath
  import usbSecGatePkg::*;
#(
  parameter int KEEP_AW = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [KEEP_AW-1:0] busAddrLow,
  input  logic [BUS_W-1:0]   busWdata,
  input  logic [BUS_W-1:0]   sramRdata,
  input  logic [REG_W-1:0]   regRdata,
  input  logic               secEn,
  output logic [KEEP_AW-1:0] addrQ,
  output logic [BUS_W-1:0]   wdataQ,
  output logic [BUS_W-1:0]   busRdata
);
  logic [BUS_W-1:0] respNx;

  always_comb begin
    unique case (strb.respSel)
      RSP_SRAM: respNx = sramRdata;
      RSP_REG:  respNx = {{(BUS_W-REG_W){1'b0}}, regRdata};
      RSP_CTRL: respNx = {{(BUS_W-1){1'b0}}, secEn};
      default:  respNx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      busRdata <= '0;
    end else begin
      if (strb.capture) begin
        addrQ  <= busAddrLow;
        wdataQ <= busWdata;
      end
      if (strb.loadResp) busRdata <= respNx;
    end
  end
endmodule

// File: rtl/usbSecGate.sv
module usbSecGate
  import usbSecGatePkg::*;
#(
  parameter int          SRAM_BYTES = 4096,
  parameter logic [31:0] REG_BASE   = 32'h0001_0000,
  parameter logic [31:0] CTRL_ADDR  = 32'h0002_0000,
  localparam int         SRAM_AW    = $clog2(SRAM_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuSecure,
  input  logic               busReq,
  input  logic               busWe,
  input  logic [31:0]        busAddr,
  input  logic [31:0]        busWdata,
  output logic               busReady,
  output logic               busErr,
  output logic [31:0]        busRdata,
  output logic               sramReq,
  output logic               sramWe,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic [31:0]        sramWdata,
  input  logic [31:0]        sramRdata,
  input  logic               sramReady,
  output logic               regReq,
  output logic               regWe,
  output logic [7:0]         regAddr,
  output logic [7:0]         regWdata,
  input  logic [7:0]         regRdata,
  input  logic               regReady
);
  localparam int KEEP_AW = (SRAM_AW > 8) ? SRAM_AW : 8;

  tgt_e               hit;
  logic               aligned;
  logic               secEn;
  strobe_t            strb;
  logic [KEEP_AW-1:0] addrQ;
  logic [31:0]        wdataQ;

  gateDecode #(
    .SRAM_AW(SRAM_AW), .REG_BASE(REG_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .addr(busAddr), .hit(hit), .aligned(aligned)
  );

  gateCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSecure(cpuSecure),
    .busReq(busReq), .busWe(busWe), .setBit(busWdata[0]),
    .hit(hit), .aligned(aligned),
    .sramReady(sramReady), .regReady(regReady),
    .busReady(busReady), .busErr(busErr),
    .sramReq(sramReq), .sramWe(sramWe),
    .regReq(regReq), .regWe(regWe),
    .secEn(secEn), .strb(strb)
  );

  gateDatapath #(.KEEP_AW(KEEP_AW)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busAddrLow(busAddr[KEEP_AW-1:0]), .busWdata(busWdata),
    .sramRdata(sramRdata), .regRdata(regRdata), .secEn(secEn),
    .addrQ(addrQ), .wdataQ(wdataQ), .busRdata(busRdata)
  );

  assign sramAddr  = addrQ[SRAM_AW-1:0];
  assign sramWdata = wdataQ;
  assign regAddr   = addrQ[7:0];
  assign regWdata  = wdataQ[7:0];
endmodule

// File: rtl/usbSecGateChk.sv
module usbSecGateChk #(
  parameter int SRAM_AW = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               cpuSecure,
  input logic               secEn,
  input logic               busReady,
  input logic               busErr,
  input logic [31:0]        busRdata,
  input logic               sramReq,
  input logic               sramReady,
  input logic [SRAM_AW-1:0] sramAddr,
  input logic               regReq,
  input logic               regReady,
  input logic [7:0]         regAddr
);
  // R2: downstream requests only appear while enabled
  a_r2_req_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (sramReq || regReq) |-> secEn);

  // R2, R7: an error response carries zero data
  a_r2_err_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    (busReady && busErr) |-> (busRdata == 32'h0));

  // R3: the bit cannot rise without secure mode
  a_r3_no_set_insecure: assert property (@(posedge clk) disable iff (!rstN)
    (!secEn && !cpuSecure) |=> !secEn);

  // R10: completion is a single-cycle pulse
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);

  // R10: SRAM request held with stable address until ready
  a_r10_sram_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sramReq && !sramReady) |=> (sramReq && $stable(sramAddr)));

  // R10: register request held with stable address until ready
  a_r10_reg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regReady) |=> (regReq && $stable(regAddr)));

  // R10: at most one downstream port busy, none during completion
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sramReq && regReq) && !(busReady && (sramReq || regReq)));
endmodule

bind usbSecGate usbSecGateChk #(.SRAM_AW(SRAM_AW)) u_chk (
  .clk(clk), .rstN(rstN), .cpuSecure(cpuSecure), .secEn(secEn),
  .busReady(busReady), .busErr(busErr), .busRdata(busRdata),
  .sramReq(sramReq), .sramReady(sramReady), .sramAddr(sramAddr),
  .regReq(regReq), .regReady(regReady), .regAddr(regAddr)
);

// File: tb/usbSecGate_tb.sv
`timescale 1ns/1ps
module usbSecGate_tb;
  localparam logic [31:0] CTRL = 32'h0002_0000;

  logic clk = 1'b0, rstN = 1'b0, cpuSecure = 1'b0;
  logic busReq = 1'b0, busWe = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic busReady, busErr;
  logic [31:0] busRdata;
  logic sramReq, sramWe, sramReady = 1'b0;
  logic [11:0] sramAddr;
  logic [31:0] sramWdata, sramRdata = '0;
  logic regReq, regWe, regReady = 1'b0;
  logic [7:0] regAddr, regWdata, regRdata = '0;

  int nChk = 0, nFail = 0;
  logic sawSram = 1'b0, sawReg = 1'b0;
  logic [11:0] lastSramAddr = '0;
  logic [31:0] lastSramData = '0;
  logic [7:0]  lastRegData = '0;

  always #5 clk = ~clk;

  usbSecGate u_dut (
    .clk(clk), .rstN(rstN), .cpuSecure(cpuSecure),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busErr(busErr), .busRdata(busRdata),
    .sramReq(sramReq), .sramWe(sramWe), .sramAddr(sramAddr),
    .sramWdata(sramWdata), .sramRdata(sramRdata), .sramReady(sramReady),
    .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regReady(regReady)
  );

  // downstream model: ready one cycle after a request appears
  initial forever begin
    @(negedge clk);
    if (sramReq) sawSram = 1'b1;
    if (regReq)  sawReg  = 1'b1;
    if (sramReq && sramWe) begin lastSramAddr = sramAddr; lastSramData = sramWdata; end
    if (regReq && regWe) lastRegData = regWdata;
    sramReady = sramReq && !sramReady;
    regReady  = regReq && !regReady;
    sramRdata = 32'hA5A5_0000 ^ {20'h0, sramAddr};
    regRdata  = regAddr ^ 8'h3C;
  end

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runAccess(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                           input logic sec, output logic err, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    sawSram = 1'b0; sawReg = 1'b0;
    busReq = 1'b1; busWe = we; busAddr = addr; busWdata = wd; cpuSecure = sec;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!busReady && cyc < 20);
    err = busErr; rd = busRdata;
    busReq = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        sec;
    logic        expErr;
    logic [31:0] expRd;
    logic [1:0]  tgt;   // 0 none, 1 SRAM, 2 register
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0010, 32'h0,         1'b0, 1'b1, 32'h0,         2'd0, 4'd2},  // R2 SRAM read blocked
    '{1'b1, 32'h0001_0004, 32'hFF,        1'b0, 1'b1, 32'h0,         2'd0, 4'd2},  // R2 reg write blocked
    '{1'b1, CTRL,          32'h1,         1'b0, 1'b0, 32'h0,         2'd0, 4'd3},  // R3 set attempt insecure
    '{1'b0, CTRL,          32'h0,         1'b0, 1'b0, 32'h0,         2'd0, 4'd3},  // R3 bit still 0
    '{1'b0, 32'h0000_0020, 32'h0,         1'b0, 1'b1, 32'h0,         2'd0, 4'd3},  // R3 still blocked
    '{1'b1, CTRL,          32'h1,         1'b1, 1'b0, 32'h0,         2'd0, 4'd4},  // R4 set in secure
    '{1'b0, CTRL,          32'h0,         1'b1, 1'b0, 32'h1,         2'd0, 4'd11}, // R11 read back 1
    '{1'b1, 32'h0000_0040, 32'hDEADBEEF,  1'b1, 1'b0, 32'h0,         2'd1, 4'd4},  // R4 SRAM write
    '{1'b0, 32'h0000_0FFC, 32'h0,         1'b1, 1'b0, 32'hA5A50FFC,  2'd1, 4'd9},  // R9 top SRAM word
    '{1'b0, 32'h0001_0008, 32'h0,         1'b1, 1'b0, 32'h34,        2'd2, 4'd8},  // R8 reg read
    '{1'b1, 32'h0000_0044, 32'h0BADF00D,  1'b0, 1'b0, 32'h0,         2'd1, 4'd5},  // R5 write after exit
    '{1'b0, 32'h0000_0048, 32'h0,         1'b0, 1'b0, 32'hA5A50048,  2'd1, 4'd5},  // R5 read after exit
    '{1'b1, 32'h0001_000C, 32'h12345678,  1'b0, 1'b0, 32'h0,         2'd2, 4'd8},  // R8 reg write low byte
    '{1'b0, 32'h0000_0042, 32'h0,         1'b0, 1'b1, 32'h0,         2'd0, 4'd7},  // R7 misaligned SRAM
    '{1'b0, 32'h0000_1000, 32'h0,         1'b0, 1'b1, 32'h0,         2'd0, 4'd9},  // R9 just past SRAM
    '{1'b0, 32'h0002_0002, 32'h0,         1'b0, 1'b1, 32'h0,         2'd0, 4'd7},  // R7 misaligned control
    '{1'b1, CTRL,          32'h0,         1'b0, 1'b0, 32'h0,         2'd0, 4'd6},  // R6 clear insecure
    '{1'b0, CTRL,          32'h0,         1'b0, 1'b0, 32'h0,         2'd0, 4'd6},  // R6 reads 0
    '{1'b0, 32'h0001_0010, 32'h0,         1'b0, 1'b1, 32'h0,         2'd0, 4'd6},  // R6 reg blocked
    '{1'b1, CTRL,          32'h1,         1'b1, 1'b0, 32'h0,         2'd0, 4'd4},  // R4 set again
    '{1'b1, CTRL,          32'h0,         1'b1, 1'b0, 32'h0,         2'd0, 4'd6},  // R6 clear in secure
    '{1'b0, 32'h0000_0000, 32'h0,         1'b1, 1'b1, 32'h0,         2'd0, 4'd6}   // R6 blocked in secure
  };

  logic done = 1'b0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic err;
    logic [31:0] rd;
    int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(1, "busReady after reset", {31'h0, busReady}, 32'h0);
    check(1, "downstream req after reset", {30'h0, sramReq, regReq}, 32'h0);
    runAccess(1'b0, CTRL, 32'h0, 1'b1, err, rd, cyc);
    check(1, "control word after reset", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      runAccess(v.we, v.addr, v.wdata, v.sec, err, rd, cyc);
      check(int'(v.req), $sformatf("vec %0d error", i), {31'h0, err}, {31'h0, v.expErr});
      check(int'(v.req), $sformatf("vec %0d rdata", i), rd, v.expRd);
      check(int'(v.req), $sformatf("vec %0d target", i), {30'h0, sawReg, sawSram},
            {30'h0, v.tgt == 2'd2, v.tgt == 2'd1});
      // R10 completion latency
      check(10, $sformatf("vec %0d cycles", i), cyc, (v.tgt != 2'd0) ? 32'd2 : 32'd1);
      if (v.we && v.tgt == 2'd1) begin
        check(int'(v.req), $sformatf("vec %0d SRAM wdata", i), lastSramData, v.wdata);
        check(int'(v.req), $sformatf("vec %0d SRAM addr", i), {20'h0, lastSramAddr}, {20'h0, v.addr[11:0]});
      end
      if (v.we && v.tgt == 2'd2)
        check(8, $sformatf("vec %0d reg wdata", i), {24'h0, lastRegData}, {24'h0, v.wdata[7:0]});
    end

    // R1: reset clears a set enable bit
    runAccess(1'b1, CTRL, 32'h1, 1'b1, err, rd, cyc);
    runAccess(1'b0, CTRL, 32'h0, 1'b0, err, rd, cyc);
    check(11, "bit set before reset", rd, 32'h1);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    runAccess(1'b0, CTRL, 32'h0, 1'b0, err, rd, cyc);
    check(1, "control word cleared by reset", rd, 32'h0);
    runAccess(1'b0, 32'h0000_0080, 32'h0, 1'b0, err, rd, cyc);
    check(1, "SRAM refused after reset", {31'h0, err}, 32'h1);
    check(1, "no SRAM req after reset", {31'h0, sawSram}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule